// File: doc/BRIEF.md
# Programmable Serial Clock Generator

This block derives the serial flash clock from the system clock while a flash transaction is in progress. A 32-bit clock-control word sets the period in system cycles and the count at which the clock rises inside that period. Alongside the clock it gives the transaction sequencer two single-cycle strobes: one marks where new output data should be launched (the falling edge) and one marks where input data should be captured (the rising edge). A bypass bit makes the serial clock follow the system clock directly, with both strobes asserted every cycle.

The control word has five fields. Bit 31 selects bypass. Bits [30:18] are a prescale field that is carried but has no effect. Bits [17:12] hold the period length minus one. Bits [11:6] hold the last count of the low phase. Bits [5:0] hold a low-phase count that software writes but the generator does not use. The word is captured when a transaction starts and again at each period boundary, so software may rewrite it mid-transaction without corrupting the current period. When no transaction is active, the clock and both strobes stay low.

Top module: `sclk_gen`

## Requirements
- R1: While rst_ni is low or active_i is low, sclk_o, launch_o and sample_o are all 0. This holds in bypass as well, and it holds while clk_i is high.
- R2: When active_i is first sampled high at a rising clk_i edge, count 0 of the first period is presented in the next cycle. When active_i is sampled low, all outputs return to 0 after the next edge.
- R3: A period lasts D = cfg_i[17:12] + 1 system cycles. A field value of 0 is treated as 1, which gives a period of 2.
- R4: Within a period the count runs from 0 to D-1. sclk_o is 0 for counts 0..H and 1 for counts H+1..D-1, where H is cfg_i[11:6].
- R5: If cfg_i[11:6] is D-1 or larger, H is clamped to D-2, so every period has at least one high cycle.
- R6: launch_o is 1 for exactly the count-0 cycle of every period.
- R7: sample_o is 1 for exactly the count-(H+1) cycle of every period, which is the first high cycle of sclk_o.
- R8: Neither the low-phase field cfg_i[5:0] nor the prescale field cfg_i[30:18] changes any output.
- R9: cfg_i is captured only at activation and in the last cycle of a period. A change made partway through a period takes effect at count 0 of the next period.
- R10: With cfg_i[31] = 1 and active, sclk_o equals clk_i, and launch_o and sample_o are 1 in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| active_i | input | 1 | Transaction in progress; the clock runs only while this is high |
| cfg_i | input | 32 | Clock-control word |
| sclk_o | output | 1 | Serial flash clock |
| launch_o | output | 1 | One-cycle strobe at the falling-edge count |
| sample_o | output | 1 | One-cycle strobe at the rising-edge count |

## Verification
A wrong count or a wrong captured configuration shows up at the ports within one period. The strobe position, the sclk_o level or the period length differs from the cycle-by-cycle model in the first cycle where they diverge. A faulty capture rule shows up in the period that follows a mid-period rewrite of cfg_i, as a shortened period or a misplaced rising edge. Faulty idle gating shows up in the cycle after active_i falls, with clk_i either low or high.

// File: rtl/sclk_pkg.sv
package sclk_pkg;
  localparam int CFG_W   = 32;
  localparam int FLD_W   = 6;
  localparam int BYP_BIT = 31;
  localparam int DIV_LSB = 12;
  localparam int HI_LSB  = 6;
endpackage

// File: rtl/sclk_cfg_decode.sv
module sclk_cfg_decode #(
  parameter int CFG_W   = sclk_pkg::CFG_W,
  parameter int FLD_W   = sclk_pkg::FLD_W,
  parameter int BYP_BIT = sclk_pkg::BYP_BIT,
  parameter int DIV_LSB = sclk_pkg::DIV_LSB,
  parameter int HI_LSB  = sclk_pkg::HI_LSB
) (
  input  logic [CFG_W-1:0] cfg_i,
  output logic             byp_o,
  output logic [FLD_W-1:0] dm1_o,
  output logic [FLD_W-1:0] hi_o
);
  logic [FLD_W-1:0] raw_dm1, raw_hi;

  assign raw_dm1 = cfg_i[DIV_LSB +: FLD_W];
  assign raw_hi  = cfg_i[HI_LSB +: FLD_W];
  assign byp_o   = cfg_i[BYP_BIT];

  always_comb begin
    dm1_o = (raw_dm1 == '0) ? FLD_W'(1) : raw_dm1;
    // keep at least one high cycle per period
    hi_o  = (raw_hi >= dm1_o) ? dm1_o - FLD_W'(1) : raw_hi;
  end
endmodule

// File: rtl/sclk_phase_cnt.sv
module sclk_phase_cnt #(
  parameter int FLD_W = sclk_pkg::FLD_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             active_i,
  input  logic             byp_i,
  input  logic [FLD_W-1:0] dm1_i,
  input  logic [FLD_W-1:0] hi_i,
  output logic             run_o,
  output logic [FLD_W-1:0] cnt_o,
  output logic             byp_o,
  output logic [FLD_W-1:0] dm1_o,
  output logic [FLD_W-1:0] hi_o
);
  logic             run_q, byp_q;
  logic [FLD_W-1:0] cnt_q, dm1_q, hi_q;
  logic             reload;

  assign reload = !run_q || (cnt_q == dm1_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      cnt_q <= '0;
      byp_q <= 1'b0;
      dm1_q <= FLD_W'(1);
      hi_q  <= '0;
    end else if (!active_i) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (reload) begin
      run_q <= 1'b1;
      cnt_q <= '0;
      byp_q <= byp_i;
      dm1_q <= dm1_i;
      hi_q  <= hi_i;
    end else begin
      cnt_q <= cnt_q + FLD_W'(1);
    end
  end

  assign run_o = run_q;
  assign cnt_o = cnt_q;
  assign byp_o = byp_q;
  assign dm1_o = dm1_q;
  assign hi_o  = hi_q;
endmodule

// File: rtl/sclk_out_decode.sv
module sclk_out_decode #(
  parameter int FLD_W = sclk_pkg::FLD_W
) (
  input  logic             clk_i,
  input  logic             run_i,
  input  logic             byp_i,
  input  logic [FLD_W-1:0] cnt_i,
  input  logic [FLD_W-1:0] hi_i,
  output logic             sclk_o,
  output logic             launch_o,
  output logic             sample_o
);
  logic [FLD_W:0] rise_cnt;
  logic           phase_hi;

  assign rise_cnt = {1'b0, hi_i} + (FLD_W+1)'(1);
  assign phase_hi = cnt_i > hi_i;

  always_comb begin
    sclk_o   = run_i & (byp_i ? clk_i : phase_hi);
    launch_o = run_i & (byp_i | (cnt_i == '0));
    sample_o = run_i & (byp_i | ({1'b0, cnt_i} == rise_cnt));
  end
endmodule

// File: rtl/sclk_gen.sv
module sclk_gen #(
  parameter int CFG_W   = sclk_pkg::CFG_W,
  parameter int FLD_W   = sclk_pkg::FLD_W,
  parameter int BYP_BIT = sclk_pkg::BYP_BIT,
  parameter int DIV_LSB = sclk_pkg::DIV_LSB,
  parameter int HI_LSB  = sclk_pkg::HI_LSB
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             active_i,
  input  logic [CFG_W-1:0] cfg_i,
  output logic             sclk_o,
  output logic             launch_o,
  output logic             sample_o
);
  logic             dec_byp;
  logic [FLD_W-1:0] dec_dm1, dec_hi;
  logic             run_w, byp_w;
  logic [FLD_W-1:0] cnt_w, dm1_w, hi_w;

  sclk_cfg_decode #(
    .CFG_W(CFG_W), .FLD_W(FLD_W), .BYP_BIT(BYP_BIT),
    .DIV_LSB(DIV_LSB), .HI_LSB(HI_LSB)
  ) u_dec (
    .cfg_i(cfg_i), .byp_o(dec_byp), .dm1_o(dec_dm1), .hi_o(dec_hi)
  );

  sclk_phase_cnt #(.FLD_W(FLD_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .active_i(active_i),
    .byp_i(dec_byp), .dm1_i(dec_dm1), .hi_i(dec_hi),
    .run_o(run_w), .cnt_o(cnt_w), .byp_o(byp_w), .dm1_o(dm1_w), .hi_o(hi_w)
  );

  sclk_out_decode #(.FLD_W(FLD_W)) u_out (
    .clk_i(clk_i), .run_i(run_w), .byp_i(byp_w), .cnt_i(cnt_w), .hi_i(hi_w),
    .sclk_o(sclk_o), .launch_o(launch_o), .sample_o(sample_o)
  );
endmodule

// File: rtl/sclk_gen_chk.sv
module sclk_gen_chk #(
  parameter int FLD_W = sclk_pkg::FLD_W
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             active_i,
  input logic             sclk_o,
  input logic             launch_o,
  input logic             sample_o,
  input logic             run_i,
  input logic             byp_i,
  input logic [FLD_W-1:0] cnt_i,
  input logic [FLD_W-1:0] dm1_i
);
  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && !$past(active_i)) |-> (!launch_o && !sample_o)); // R1

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_i <= dm1_i)); // R3

  AST_LAUNCH_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (launch_o && !byp_i) |-> !sclk_o); // R6

  AST_SAMPLE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_o && !byp_i) |-> sclk_o); // R7

  AST_STROBE_APART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !byp_i |-> !(launch_o && sample_o)); // R5

  AST_CFG_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && run_i && $past(run_i) && cnt_i != '0) |-> $stable(dm1_i)); // R9
endmodule

bind sclk_gen sclk_gen_chk #(.FLD_W(FLD_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .active_i(active_i),
  .sclk_o(sclk_o), .launch_o(launch_o), .sample_o(sample_o),
  .run_i(run_w), .byp_i(byp_w), .cnt_i(cnt_w), .dm1_i(dm1_w)
);

// File: tb/sim_sclk_gen.sv
`timescale 1ns/1ps
module sim_sclk_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        active = 1'b0;
  logic [31:0] cfg = '0;
  logic        sclk, launch, sample;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  sclk_gen u0 (
    .clk_i(clk), .rst_ni(rst_n), .active_i(active), .cfg_i(cfg),
    .sclk_o(sclk), .launch_o(launch), .sample_o(sample)
  );

  // cfg word: {bypass, prescale[12:0], div-1[5:0], high[5:0], low[5:0]}
  localparam int NV = 7;
  localparam logic [31:0] VCFG [NV] = '{
    {1'b0, 13'h0,    6'd1,  6'd0,  6'd1},
    {1'b0, 13'h0,    6'd3,  6'd1,  6'd3},
    {1'b0, 13'h0,    6'd62, 6'd30, 6'd62},
    {1'b0, 13'h0,    6'd6,  6'd2,  6'd6},
    {1'b0, 13'h0,    6'd5,  6'd40, 6'd5},
    {1'b0, 13'h0,    6'd0,  6'd9,  6'd0},
    {1'b0, 13'h1fff, 6'd3,  6'd1,  6'd45}
  };
  // expected {period, effective high count}
  localparam int VPER [NV] = '{2, 4, 63, 7, 6, 2, 4};
  localparam int VHI  [NV] = '{0, 1, 30, 2, 4, 0, 1};

  task automatic chk(string req, logic got, logic exp, string what);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %b expected %b at %0t", req, what, got, exp, $time);
    end
  endtask

  task automatic chk_idle(string req);
    chk(req, sclk, 1'b0, "sclk idle");
    chk(req, launch, 1'b0, "launch idle");
    chk(req, sample, 1'b0, "sample idle");
  endtask

  task automatic chk_cyc(string req, int c, int h);
    chk(req, sclk,   (c > h) ? 1'b1 : 1'b0, $sformatf("sclk cnt=%0d", c));
    chk(req, launch, (c == 0) ? 1'b1 : 1'b0, $sformatf("launch cnt=%0d", c));
    chk(req, sample, (c == h + 1) ? 1'b1 : 1'b0, $sformatf("sample cnt=%0d", c));
  endtask

  task automatic start(logic [31:0] c);
    @(negedge clk);
    cfg = c;
    active = 1'b1;
    #1 chk_idle("R2");
    @(posedge clk);
  endtask

  task automatic stop();
    @(negedge clk);
    active = 1'b0;
    @(negedge clk);
    #1 chk_idle("R2");
  endtask

  initial begin
    // reset: outputs quiet even with active high
    active = 1'b1;
    cfg = {1'b1, 31'h0};
    repeat (3) @(negedge clk);
    #1 chk_idle("R1");
    @(posedge clk);
    #1 chk("R1", sclk, 1'b0, "sclk in reset, clk high");
    @(negedge clk);
    active = 1'b0;
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    #1 chk_idle("R1");

    // table walk: R3 R4 R5 R6 R7 R8
    for (int v = 0; v < NV; v++) begin
      start(VCFG[v]);
      for (int t = 0; t < 2 * VPER[v]; t++) begin
        @(negedge clk);
        #1 chk_cyc($sformatf("R3/R4/R6/R7 vec%0d", v), t % VPER[v], VHI[v]);
      end
      stop();
    end

    // R9: rewrite mid-period (div4 -> div2) takes effect at next count 0
    start({1'b0, 13'h0, 6'd3, 6'd1, 6'd3});
    for (int t = 0; t < 8; t++) begin
      @(negedge clk);
      #1;
      if (t < 4) chk_cyc("R9", t, 1);
      else       chk_cyc("R9", (t - 4) % 2, 0);
      if (t == 1) cfg = {1'b0, 13'h0, 6'd1, 6'd0, 6'd1};
    end
    stop();

    // R10: bypass follows clk_i, strobes every cycle
    start({1'b1, 13'h0, 6'd3, 6'd1, 6'd3});
    for (int t = 0; t < 3; t++) begin
      @(posedge clk);
      #1;
      chk("R10", sclk, 1'b1, "bypass sclk high phase");
      chk("R10", launch, 1'b1, "bypass launch");
      chk("R10", sample, 1'b1, "bypass sample");
      @(negedge clk);
      #1 chk("R10", sclk, 1'b0, "bypass sclk low phase");
    end
    active = 1'b0;
    @(posedge clk);
    @(posedge clk);
    #1;
    chk("R1", sclk, 1'b0, "bypass idle sclk, clk high");
    chk("R1", launch, 1'b0, "bypass idle launch");

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule